// File: doc/BRIEF.md
# Transmit Word Alignment Controller

This block runs the transmit half of a serial link start-up against a word clock that lives at the far end of the link. When it leaves reset, it sends a fixed reset pattern. That pattern asks the far end to begin initialization. Once the local receiver reports lock, the block switches to sending ALIGN control words without a break.

The far end gives no direct report on whether the transmit word boundary is correct. It keeps answering with ALIGN words for as long as the boundary is wrong. The controller counts those returned ALIGN words. After each fixed group of them, it issues a one-cycle slip command that moves its transmit word boundary by one bit. It also keeps a boundary pointer that wraps around the number of bit positions in a line word.

When the far end answers with a short run of IDLE words, the controller declares transmit lock on an active-low flag. From then on it forwards the user data and type words unchanged. If receive lock is lost while the block is aligning or linked, it starts over from the reset request.

Top module: `txalign_ctrl`

## Requirements
- R1: After reset, tx_word carries the reset pattern 32'h5A5AF00F with tx_type 2'b11, tx_lock_n is 1, tx_slip is 0 and tx_bound is 0.
- R2: For the first REQ_LEN cycles after reset the reset pattern is sent whatever rx_lock_n does. After that it keeps being sent until a cycle with rx_lock_n low, and aligning starts at the next clock edge.
- R3: While aligning, tx_word is the ALIGN pattern 32'hA1F0A1F0 with tx_type 2'b11 in every cycle.
- R4: While aligning, every SLIP_GROUP-th received ALIGN word (rx_word 32'hA1F0A1F0 with rx_type 2'b11) raises tx_slip for exactly one cycle, in the cycle after that word. The count then starts again. Other received words neither advance the count nor clear it.
- R5: tx_bound advances by one in the same cycle that tx_slip is high, wraps from POSITIONS-1 to 0, and otherwise holds.
- R6: The received-ALIGN count is cleared each time aligning is entered, so ALIGN words counted before a loss of lock do not carry over.
- R7: Transmit lock (tx_lock_n low) is declared at the clock edge after IDLE_RUN consecutive IDLE words (rx_word 32'h1D1E1D1E with rx_type 2'b11) have been received while aligning. Any other word restarts the run, so a single IDLE word does not link.
- R8: While linked, tx_lock_n is 0 and tx_word/tx_type equal usr_data/usr_type in the same cycle. Received ALIGN words cause no slip.
- R9: rx_lock_n high while aligning or linked returns the block to the reset request at the next edge: tx_lock_n 1 and the reset pattern on tx_word.
- R10: Outside the linked state, usr_data and usr_type have no effect on tx_word or tx_type.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_lock_n | input | 1 | Receive word lock, low when locked |
| rx_word | input | WORD_W | Word received from the far end |
| rx_type | input | TYPE_W | Type code of the received word |
| usr_data | input | WORD_W | User transmit data word |
| usr_type | input | TYPE_W | User transmit type code |
| tx_word | output | WORD_W | Word to the serializer |
| tx_type | output | TYPE_W | Type code to the serializer |
| tx_lock_n | output | 1 | Transmit lock, low when linked |
| tx_slip | output | 1 | One-cycle boundary slip command |
| tx_bound | output | clog2(POSITIONS) | Current transmit boundary position |

## Verification
The bench builds the block with SLIP_GROUP=4, IDLE_RUN=2, REQ_LEN=3 and the default POSITIONS=34. The small group size makes a full wrap of the boundary pointer take only 136 ALIGN words. That brings the 33-to-0 wrap, a lost count after a drop of lock, and interleaved IDLE/ALIGN runs into a short run. POSITIONS is kept at 34, which is not a power of two, so the explicit-compare wrap branch is the one exercised.

// File: rtl/txa_pkg.sv
package txa_pkg;

   typedef enum logic [1:0] {
      ST_REQ   = 2'd0,
      ST_WAIT  = 2'd1,
      ST_ALIGN = 2'd2,
      ST_LINK  = 2'd3
   } txa_state_e;

   typedef enum logic [1:0] {
      SEL_RESET = 2'd0,
      SEL_ALIGN = 2'd1,
      SEL_USER  = 2'd2
   } txa_sel_e;

endpackage

// File: rtl/txa_grp_cnt.sv
module txa_grp_cnt #(
   parameter int GROUP = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic hit,
   output logic slip_now,
   output logic slip
);
   localparam int CW = (GROUP > 2) ? $clog2(GROUP) : 1;

   if (GROUP < 2) begin : g_bad_group
      $error("txa_grp_cnt: GROUP must be at least 2");
   end

   logic [CW-1:0] cnt;

   assign slip_now = !clr && hit && (cnt == CW'(GROUP - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt  <= '0;
         slip <= 1'b0;
      end else begin
         slip <= slip_now;
         if (clr || slip_now) begin
            cnt <= '0;
         end else if (hit) begin
            cnt <= cnt + CW'(1);
         end
      end
   end

   // R4
   slip_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      slip |=> !slip);

   // R4
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      32'(cnt) < GROUP);

   // R6
   cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0));
endmodule

// File: rtl/txa_idle_run.sv
module txa_idle_run #(
   parameter int RUN = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic idle,
   output logic done
);
   if (RUN < 1) begin : g_bad_run
      $error("txa_idle_run: RUN must be at least 1");
   end

   if (RUN == 1) begin : g_single
      assign done = idle && !clr;
   end else begin : g_multi
      localparam int RW = $clog2(RUN);
      logic [RW-1:0] run;

      assign done = idle && !clr && (run == RW'(RUN - 1));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            run <= '0;
         end else if (clr || !idle || done) begin
            run <= '0;
         end else begin
            run <= run + RW'(1);
         end
      end

      // R7
      run_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!idle || clr) |=> (run == '0));
   end
endmodule

// File: rtl/txa_bound_ptr.sv
module txa_bound_ptr #(
   parameter int POSITIONS = 34,
   localparam int BW = $clog2(POSITIONS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step,
   output logic [BW-1:0] ptr
);
   if (POSITIONS < 2) begin : g_bad_pos
      $error("txa_bound_ptr: POSITIONS must be at least 2");
   end

   if ((1 << BW) == POSITIONS) begin : g_pow2
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ptr <= '0;
         end else if (step) begin
            ptr <= ptr + BW'(1);
         end
      end
   end else begin : g_cmp
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ptr <= '0;
         end else if (step) begin
            ptr <= (ptr == BW'(POSITIONS - 1)) ? '0 : ptr + BW'(1);
         end
      end

      // R5
      ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
         32'(ptr) < POSITIONS);
   end
endmodule

// File: rtl/txa_word_mux.sv
module txa_word_mux
   import txa_pkg::*;
#(
   parameter int          WORD_W    = 32,
   parameter int          TYPE_W    = 2,
   parameter logic [WORD_W-1:0] RESET_PAT = 32'h5A5AF00F,
   parameter logic [WORD_W-1:0] ALIGN_PAT = 32'hA1F0A1F0,
   parameter logic [TYPE_W-1:0] CTRL_TYPE = 2'b11
) (
   input  txa_sel_e          sel,
   input  logic [WORD_W-1:0] usr_data,
   input  logic [TYPE_W-1:0] usr_type,
   output logic [WORD_W-1:0] word,
   output logic [TYPE_W-1:0] wtype
);
   always_comb begin
      unique case (sel)
         SEL_USER: begin
            word  = usr_data;
            wtype = usr_type;
         end
         SEL_ALIGN: begin
            word  = ALIGN_PAT;
            wtype = CTRL_TYPE;
         end
         default: begin
            word  = RESET_PAT;
            wtype = CTRL_TYPE;
         end
      endcase
   end

   // R10
   always_comb begin
      if (sel != SEL_USER) begin
         ctrl_type_chk: assert (wtype == CTRL_TYPE);
      end
   end
endmodule

// File: rtl/txalign_ctrl.sv
module txalign_ctrl
   import txa_pkg::*;
#(
   parameter int WORD_W     = 32,
   parameter int TYPE_W     = 2,
   parameter int SLIP_GROUP = 32,
   parameter int IDLE_RUN   = 2,
   parameter int POSITIONS  = 34,
   parameter int REQ_LEN    = 16,
   parameter logic [WORD_W-1:0] RESET_PAT = 32'h5A5AF00F,
   parameter logic [WORD_W-1:0] ALIGN_PAT = 32'hA1F0A1F0,
   parameter logic [WORD_W-1:0] IDLE_PAT  = 32'h1D1E1D1E,
   parameter logic [TYPE_W-1:0] CTRL_TYPE = 2'b11,
   localparam int BW = $clog2(POSITIONS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_lock_n,
   input  logic [WORD_W-1:0] rx_word,
   input  logic [TYPE_W-1:0] rx_type,
   input  logic [WORD_W-1:0] usr_data,
   input  logic [TYPE_W-1:0] usr_type,
   output logic [WORD_W-1:0] tx_word,
   output logic [TYPE_W-1:0] tx_type,
   output logic              tx_lock_n,
   output logic              tx_slip,
   output logic [BW-1:0]     tx_bound
);
   localparam int RQW = (REQ_LEN > 2) ? $clog2(REQ_LEN) : 1;

   if (REQ_LEN < 2) begin : g_bad_req
      $error("txalign_ctrl: REQ_LEN must be at least 2");
   end
   if (ALIGN_PAT == IDLE_PAT) begin : g_bad_pat
      $error("txalign_ctrl: ALIGN and IDLE patterns must differ");
   end

   txa_state_e    st, st_nxt;
   logic [RQW-1:0] req_cnt;
   logic          rx_align, rx_idle;
   logic          aligning, cnt_clr;
   logic          idle_done, slip_now;
   txa_sel_e      sel;

   assign rx_align = (rx_type == CTRL_TYPE) && (rx_word == ALIGN_PAT);
   assign rx_idle  = (rx_type == CTRL_TYPE) && (rx_word == IDLE_PAT);
   assign aligning = (st == ST_ALIGN);
   assign cnt_clr  = !aligning || rx_lock_n;

   always_comb begin
      st_nxt = st;
      unique case (st)
         ST_REQ:   if (req_cnt == RQW'(REQ_LEN - 1)) st_nxt = ST_WAIT;
         ST_WAIT:  if (!rx_lock_n) st_nxt = ST_ALIGN;
         ST_ALIGN: begin
            if (rx_lock_n)      st_nxt = ST_REQ;
            else if (idle_done) st_nxt = ST_LINK;
         end
         default:  if (rx_lock_n) st_nxt = ST_REQ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= ST_REQ;
         req_cnt <= '0;
      end else begin
         st      <= st_nxt;
         req_cnt <= (st == ST_REQ) ? req_cnt + RQW'(1) : '0;
      end
   end

   txa_grp_cnt #(.GROUP(SLIP_GROUP)) u_grp (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (cnt_clr),
      .hit      (rx_align),
      .slip_now (slip_now),
      .slip     (tx_slip)
   );

   txa_idle_run #(.RUN(IDLE_RUN)) u_idle (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cnt_clr),
      .idle  (rx_idle),
      .done  (idle_done)
   );

   txa_bound_ptr #(.POSITIONS(POSITIONS)) u_bound (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (slip_now),
      .ptr   (tx_bound)
   );

   always_comb begin
      unique case (st)
         ST_ALIGN: sel = SEL_ALIGN;
         ST_LINK:  sel = SEL_USER;
         default:  sel = SEL_RESET;
      endcase
   end

   txa_word_mux #(
      .WORD_W    (WORD_W),
      .TYPE_W    (TYPE_W),
      .RESET_PAT (RESET_PAT),
      .ALIGN_PAT (ALIGN_PAT),
      .CTRL_TYPE (CTRL_TYPE)
   ) u_mux (
      .sel      (sel),
      .usr_data (usr_data),
      .usr_type (usr_type),
      .word     (tx_word),
      .wtype    (tx_type)
   );

   assign tx_lock_n = (st != ST_LINK);

   // R9
   lock_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == ST_ALIGN || st == ST_LINK) && rx_lock_n)
      |=> (tx_lock_n && tx_word == RESET_PAT));

   // R8
   link_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_lock_n |-> (tx_word == usr_data && tx_type == usr_type));

   // R8
   link_noslip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_lock_n && $past(!tx_lock_n)) |-> !tx_slip);

   // R5
   bound_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_slip && $past(tx_bound) != BW'(POSITIONS - 1))
      |-> (tx_bound == $past(tx_bound) + BW'(1)));

   // R5
   bound_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_slip |-> $stable(tx_bound));

   // R3
   align_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_ALIGN) |-> (tx_word == ALIGN_PAT && tx_lock_n));
endmodule

// File: tb/sim_txalign_ctrl.sv
module sim_txalign_ctrl;
   localparam int GRP  = 4;
   localparam int RUNL = 2;
   localparam int POS  = 34;
   localparam int REQ  = 3;
   localparam logic [31:0] RST_W = 32'h5A5AF00F;
   localparam logic [31:0] ALN_W = 32'hA1F0A1F0;
   localparam logic [31:0] IDL_W = 32'h1D1E1D1E;
   localparam logic [31:0] OTH_W = 32'h01234567;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_lock_n = 1'b1;
   logic [31:0] rx_word = OTH_W;
   logic [1:0]  rx_type = 2'b00;
   logic [31:0] usr_data = 32'hC0DE0000;
   logic [1:0]  usr_type = 2'b10;
   logic [31:0] tx_word;
   logic [1:0]  tx_type;
   logic        tx_lock_n, tx_slip;
   logic [5:0]  tx_bound;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #2 clk = ~clk;

   txalign_ctrl #(
      .SLIP_GROUP (GRP),
      .IDLE_RUN   (RUNL),
      .POSITIONS  (POS),
      .REQ_LEN    (REQ)
   ) u0 (
      .clk, .rst_n, .rx_lock_n, .rx_word, .rx_type, .usr_data, .usr_type,
      .tx_word, .tx_type, .tx_lock_n, .tx_slip, .tx_bound
   );

   // {lock_n, sym(0 other,1 align,2 idle), kind(0 reset,1 align,2 user), exp_lock_n, exp_slip, exp_bound}
   localparam logic [12:0] VEC [0:19] = '{
      {1'b1, 2'd0, 2'd0, 1'b1, 1'b0, 6'd0},
      {1'b0, 2'd0, 2'd0, 1'b1, 1'b0, 6'd0},
      {1'b1, 2'd0, 2'd0, 1'b1, 1'b0, 6'd0},
      {1'b1, 2'd0, 2'd0, 1'b1, 1'b0, 6'd0},
      {1'b0, 2'd0, 2'd1, 1'b1, 1'b0, 6'd0},
      {1'b0, 2'd1, 2'd1, 1'b1, 1'b0, 6'd0},
      {1'b0, 2'd1, 2'd1, 1'b1, 1'b0, 6'd0},
      {1'b0, 2'd1, 2'd1, 1'b1, 1'b0, 6'd0},
      {1'b0, 2'd1, 2'd1, 1'b1, 1'b1, 6'd1},
      {1'b0, 2'd0, 2'd1, 1'b1, 1'b0, 6'd1},
      {1'b0, 2'd1, 2'd1, 1'b1, 1'b0, 6'd1},
      {1'b0, 2'd2, 2'd1, 1'b1, 1'b0, 6'd1},
      {1'b0, 2'd1, 2'd1, 1'b1, 1'b0, 6'd1},
      {1'b0, 2'd2, 2'd1, 1'b1, 1'b0, 6'd1},
      {1'b0, 2'd0, 2'd1, 1'b1, 1'b0, 6'd1},
      {1'b0, 2'd2, 2'd1, 1'b1, 1'b0, 6'd1},
      {1'b0, 2'd2, 2'd2, 1'b0, 1'b0, 6'd1},
      {1'b0, 2'd0, 2'd2, 1'b0, 1'b0, 6'd1},
      {1'b0, 2'd1, 2'd2, 1'b0, 1'b0, 6'd1},
      {1'b1, 2'd0, 2'd0, 1'b1, 1'b0, 6'd1}
   };

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic set_sym(input logic [1:0] s);
      case (s)
         2'd1:    begin rx_word = ALN_W; rx_type = 2'b11; end
         2'd2:    begin rx_word = IDL_W; rx_type = 2'b11; end
         default: begin rx_word = OTH_W; rx_type = 2'b00; end
      endcase
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      rx_lock_n = 1'b1;
      set_sym(2'd0);
      repeat (3) step();
      rst_n = 1'b1;
      // R1
      chk(tx_word == RST_W && tx_type == 2'b11, "R1 word", {30'd0, tx_type, tx_word}, {30'd0, 2'b11, RST_W});
      chk(tx_lock_n && !tx_slip && tx_bound == 0, "R1 flags", {56'd0, tx_lock_n, tx_slip, tx_bound}, {56'd0, 1'b1, 1'b0, 6'd0});
   endtask

   task automatic goto_align();
      rx_lock_n = 1'b0;
      set_sym(2'd0);
      for (int i = 0; i < 10 && tx_word != ALN_W; i++) step();
      chk(tx_word == ALN_W, "R2 reach align", {32'd0, tx_word}, {32'd0, ALN_W});
   endtask

   task automatic feed_align(input int n);
      set_sym(2'd1);
      for (int i = 0; i < n; i++) step();
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      do_reset();

      for (int v = 0; v < 20; v++) begin
         logic [12:0] e;
         logic [31:0] ew;
         logic [1:0]  et;
         e = VEC[v];
         rx_lock_n = e[12];
         set_sym(e[11:10]);
         usr_data = 32'hC0DE0000 | 32'(v);
         usr_type = 2'b10;
         step();
         case (e[9:8])
            2'd1:    begin ew = ALN_W; et = 2'b11; end
            2'd2:    begin ew = usr_data; et = usr_type; end
            default: begin ew = RST_W; et = 2'b11; end
         endcase
         // R2 R3 R8 R10 word selection, R7 R9 lock flag, R4 slip, R5 pointer
         chk(tx_word == ew && tx_type == et, "R2/R3/R8 table word", {30'd0, tx_type, tx_word}, {30'd0, et, ew});
         chk(tx_lock_n == e[7], "R7/R9 table lock", 64'(tx_lock_n), 64'(e[7]));
         chk(tx_slip == e[6], "R4 table slip", 64'(tx_slip), 64'(e[6]));
         chk(tx_bound == e[5:0], "R5 table bound", 64'(tx_bound), 64'(e[5:0]));
      end

      // R5 full wrap of the boundary pointer
      do_reset();
      goto_align();
      for (int g = 0; g < POS; g++) begin
         feed_align(GRP - 1);
         chk(!tx_slip, "R4 no early slip", 64'(tx_slip), 64'd0);
         feed_align(1);
         chk(tx_slip, "R4 group slip", 64'(tx_slip), 64'd1);
         chk(tx_bound == 6'((g + 1) % POS), "R5 wrap step", 64'(tx_bound), 64'((g + 1) % POS));
      end
      set_sym(2'd0);
      step();
      chk(!tx_slip && tx_bound == 0, "R5 after wrap", {56'd0, tx_slip, 1'b0, tx_bound}, 64'd0);

      // R6 count cleared across a loss of lock; R9 from aligning
      feed_align(GRP - 1);
      rx_lock_n = 1'b1;
      set_sym(2'd0);
      step();
      chk(tx_word == RST_W && tx_lock_n, "R9 drop in align", {31'd0, tx_lock_n, tx_word}, {31'd0, 1'b1, RST_W});
      goto_align();
      feed_align(1);
      chk(!tx_slip, "R6 stale count", 64'(tx_slip), 64'd0);
      feed_align(GRP - 2);
      chk(!tx_slip, "R6 fresh count", 64'(tx_slip), 64'd0);
      feed_align(1);
      chk(tx_slip, "R4 fresh group", 64'(tx_slip), 64'd1);

      // R10 user inputs ignored while aligning
      usr_data = ALN_W ^ 32'hFFFFFFFF;
      usr_type = 2'b01;
      set_sym(2'd0);
      step();
      chk(tx_word == ALN_W && tx_type == 2'b11, "R10 ignore user", {30'd0, tx_type, tx_word}, {30'd0, 2'b11, ALN_W});

      // R7 link then R8 forwarding then R9 drop
      set_sym(2'd2);
      step();
      chk(tx_lock_n, "R7 single idle", 64'(tx_lock_n), 64'd1);
      step();
      chk(!tx_lock_n, "R7 idle run", 64'(tx_lock_n), 64'd0);
      usr_data = 32'h89ABCDEF;
      usr_type = 2'b00;
      #1;
      chk(tx_word == 32'h89ABCDEF && tx_type == 2'b00, "R8 forward", {30'd0, tx_type, tx_word}, {30'd0, 2'b00, 32'h89ABCDEF});
      feed_align(GRP);
      chk(!tx_slip && !tx_lock_n, "R8 no slip linked", {62'd0, tx_slip, tx_lock_n}, 64'd0);
      rx_lock_n = 1'b1;
      step();
      chk(tx_lock_n && tx_word == RST_W, "R9 drop linked", {31'd0, tx_lock_n, tx_word}, {31'd0, 1'b1, RST_W});

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule